// File: doc/BRIEF.md
# Segment Descriptor Cache Unit

This block holds six segment registers, each backed by a hidden cache of base address, limit and attribute bits. A load port writes one cache. A real-mode load rewrites only the base, plus a few forced attribute bits. A protected-mode load fills the whole cache from a 64-bit descriptor. Because a real-mode load leaves the limit and most attributes alone, a flat 4 GiB limit set by a protected-mode load stays in force after the return to real mode. A segment can also stay 32-bit in real mode.

A check port takes a segment index, an offset and an access size. One cycle later it returns the linear address, the segment's cached attributes and a general-protection fault flag with its vector. The limit check applies in both modes.

Both ports use valid/ready:
- The load port never stalls, so `ld_ready` is always 1.
- The check port stalls only while a response is pending and not yet taken: `chk_ready = !rsp_valid || rsp_ready`.
- A response held by a low `rsp_ready` keeps every response field stable until it is accepted.

Top module: `seg_cache_unit`

## Requirements
- R1: After reset, segment indices are CS=0, SS=1, DS=2, ES=3, FS=4, GS=5. Every cache has base 0 and limit 0xFFFF. CS has base 0xFFFF0000. Attributes read on `rsp_attr` as {P[9], DPL[8:7], S[6], E[5], DC[4], RW[3], A[2], G[1], D[0]}. This is 0x24C for data segments and 0x26C for CS.
- R2: A real-mode load (`ld_pm`=0) sets the cached base to `ld_sel`×16 and leaves the cached limit unchanged.
- R3: A protected-mode load fills the cache from the descriptor fields:
  - base from bits [63:56], [39:32] and [31:16];
  - limit from bits [51:48] and [15:0];
  - P, DPL, S, E, DC, RW and A from bits 47, 46:45, 44, 43, 42, 41 and 40;
  - G from bit 55 and D from bit 54.
- R4: When G is set, the 20-bit limit is shifted left by 12 with the low 12 bits set to ones. Descriptor 0x008F92000000FFFF gives limit 0xFFFFFFFF and attributes 0x24A.
- R5: An access covers 2^`chk_size` bytes. It faults if its last byte (offset + 2^size − 1, computed without wrap) exceeds the cached limit, or if the segment index is 6 or 7. A fault sets `rsp_fault`, `rsp_vec`=13 and `rsp_addr`=0. Otherwise `rsp_vec` is 0.
- R6: Without a fault, `rsp_addr` = base + offset modulo 2^32, valid in the cycle after the check is accepted.
- R7: A real-mode load of CS forces P, S, RW and A to 1 and keeps DPL, E, DC, G and D.
- R8: A real-mode load of SS, DS, ES, FS or GS forces only A to 1 and keeps every other attribute bit.
- R9: The D bit survives real-mode loads of any segment.
- R10: `ld_ready` is always 1. `chk_ready` is 0 only while `rsp_valid`=1 and `rsp_ready`=0. While the response waits, its fields do not change.
- R11: A check accepted in the same cycle as a load to the same segment sees the cache contents from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load accepted (always 1) |
| ld_seg | input | 3 | Segment index to load |
| ld_pm | input | 1 | 1 = protected-mode load, 0 = real-mode load |
| ld_sel | input | 16 | Selector or real-mode segment value |
| ld_desc | input | 64 | Descriptor for protected-mode loads |
| chk_valid | input | 1 | Check request valid |
| chk_ready | output | 1 | Check request can be accepted |
| chk_seg | input | 3 | Segment index to check |
| chk_off | input | 32 | Offset within the segment |
| chk_size | input | 2 | Log2 of access size in bytes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Linear address, 0 on fault |
| rsp_fault | output | 1 | General-protection fault |
| rsp_vec | output | 8 | Fault vector (13) or 0 |
| rsp_attr | output | 10 | Cached attributes of the checked segment |

## Verification
A load changes the cache at the edge that accepts it, so it affects the first check accepted after that edge, but not a check accepted at the same edge. A check's response is registered at its accepting edge. The bench drives every request just after a falling edge and samples the response at the next falling edge, one cycle later. For back-pressure, the bench keeps a response waiting for several cycles and confirms it is held. After release, the queued request's response arrives one cycle after the edge at which `rsp_ready` returns high.

// File: rtl/segc_pkg.sv
package segc_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEL_W   = 16;
  localparam int DESC_W  = 64;
  localparam int SEG_W   = 3;
  localparam int ATTR_W  = 10;
  localparam logic [7:0] GP_VEC = 8'd13;

  typedef struct packed {
    logic       p;
    logic [1:0] dpl;
    logic       s;
    logic       e;
    logic       dc;
    logic       rw;
    logic       a;
    logic       g;
    logic       d;
  } seg_attr_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    seg_attr_t         attr;
  } seg_cache_t;
endpackage

// File: rtl/segc_desc_decode.sv
module segc_desc_decode
  import segc_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output seg_cache_t        dec
);
  logic [19:0] raw_lim;

  always_comb begin
    raw_lim        = {desc[51:48], desc[15:0]};
    dec.base       = {desc[63:56], desc[39:32], desc[31:16]};
    dec.attr.p     = desc[47];
    dec.attr.dpl   = desc[46:45];
    dec.attr.s     = desc[44];
    dec.attr.e     = desc[43];
    dec.attr.dc    = desc[42];
    dec.attr.rw    = desc[41];
    dec.attr.a     = desc[40];
    dec.attr.g     = desc[55];
    dec.attr.d     = desc[54];
    dec.limit      = desc[55] ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
  end
endmodule

// File: rtl/segc_bank.sv
module segc_bank
  import segc_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int CODE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_fire,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic              ld_pm,
  input  logic [SEL_W-1:0]  ld_sel,
  input  seg_cache_t        ld_dec,
  input  logic [SEG_W-1:0]  rd_seg,
  output seg_cache_t        rd_data,
  output logic              rd_ok
);
  seg_cache_t cache_q [NUM_SEG];
  logic [ADDR_W-1:0] rm_base;

  assign rm_base = {{(ADDR_W-SEL_W-4){1'b0}}, ld_sel, 4'b0000};

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam bit IS_CODE = (i == CODE_IDX);
    logic hit;
    assign hit = ld_fire && (ld_seg == SEG_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cache_q[i].base  <= IS_CODE ? 32'hFFFF_0000 : '0;
        cache_q[i].limit <= 32'h0000_FFFF;
        cache_q[i].attr  <= '{p: 1'b1, dpl: 2'b00, s: 1'b1, e: IS_CODE,
                              dc: 1'b0, rw: 1'b1, a: 1'b1, g: 1'b0, d: 1'b0};
      end else if (hit) begin
        if (ld_pm) begin
          cache_q[i] <= ld_dec;
        end else begin
          cache_q[i].base   <= rm_base;
          cache_q[i].attr.a <= 1'b1;
          if (IS_CODE) begin
            cache_q[i].attr.p  <= 1'b1;
            cache_q[i].attr.s  <= 1'b1;
            cache_q[i].attr.rw <= 1'b1;
          end
        end
      end
    end

    // R2
    rm_limit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ld_pm) |=> (cache_q[i].limit == $past(cache_q[i].limit)));
    // R9
    rm_dsize_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ld_pm) |=> (cache_q[i].attr.d == $past(cache_q[i].attr.d)));
    // R8
    rm_dpl_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ld_pm) |=> (cache_q[i].attr.dpl == $past(cache_q[i].attr.dpl)
                           && cache_q[i].attr.a));
    // R4
    gran_low_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ld_pm && ld_dec.attr.g) |=> (cache_q[i].limit[11:0] == 12'hFFF));
  end

  always_comb begin
    rd_data = '0;
    rd_ok   = 1'b0;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (rd_seg == SEG_W'(k)) begin
        rd_data = cache_q[k];
        rd_ok   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/segc_check.sv
module segc_check
  import segc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [ADDR_W-1:0] chk_off,
  input  logic [1:0]        chk_size,
  input  seg_cache_t        seg,
  input  logic              seg_ok,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic [7:0]        rsp_vec,
  output logic [ATTR_W-1:0] rsp_attr
);
  logic              fire;
  logic [ADDR_W:0]   last_byte;
  logic [ADDR_W:0]   span;
  logic              fault_n;

  assign chk_ready = !rsp_valid || rsp_ready;
  assign fire      = chk_valid && chk_ready;

  always_comb begin
    span      = (ADDR_W+1)'((1 << chk_size) - 1);
    last_byte = {1'b0, chk_off} + span;
    fault_n   = !seg_ok || (last_byte > {1'b0, seg.limit});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
      rsp_vec   <= '0;
      rsp_attr  <= '0;
    end else if (chk_ready) begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_fault <= fault_n;
        rsp_vec   <= fault_n ? GP_VEC : 8'd0;
        rsp_addr  <= fault_n ? '0 : seg.base + chk_off;
        rsp_attr  <= seg.attr;
      end
    end
  end

  // R5
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0 && rsp_vec == GP_VEC));
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                   && $stable(rsp_fault) && $stable(rsp_attr)));
  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !chk_ready);
endmodule

// File: rtl/seg_cache_unit.sv
module seg_cache_unit
  import segc_pkg::*;
#(
  parameter int NUM_SEG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic [2:0]  ld_seg,
  input  logic        ld_pm,
  input  logic [15:0] ld_sel,
  input  logic [63:0] ld_desc,
  input  logic        chk_valid,
  output logic        chk_ready,
  input  logic [2:0]  chk_seg,
  input  logic [31:0] chk_off,
  input  logic [1:0]  chk_size,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault,
  output logic [7:0]  rsp_vec,
  output logic [9:0]  rsp_attr
);
  seg_cache_t dec;
  seg_cache_t rd_data;
  logic       rd_ok;

  assign ld_ready = 1'b1;

  segc_desc_decode u_dec (.desc(ld_desc), .dec(dec));

  segc_bank #(.NUM_SEG(NUM_SEG), .CODE_IDX(0)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld_fire(ld_valid), .ld_seg(ld_seg), .ld_pm(ld_pm), .ld_sel(ld_sel),
    .ld_dec(dec), .rd_seg(chk_seg), .rd_data(rd_data), .rd_ok(rd_ok)
  );

  segc_check u_chk (
    .clk(clk), .rst_n(rst_n),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_off(chk_off), .chk_size(chk_size),
    .seg(rd_data), .seg_ok(rd_ok),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .rsp_vec(rsp_vec), .rsp_attr(rsp_attr)
  );

  // R10
  ld_always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ld_ready);
endmodule

// File: tb/sim_seg_cache_unit.sv
module sim_seg_cache_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [2:0]  ld_seg = '0;
  logic        ld_pm = 1'b0;
  logic [15:0] ld_sel = '0;
  logic [63:0] ld_desc = '0;
  logic        chk_valid = 1'b0;
  logic        chk_ready;
  logic [2:0]  chk_seg = '0;
  logic [31:0] chk_off = '0;
  logic [1:0]  chk_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic [7:0]  rsp_vec;
  logic [9:0]  rsp_attr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_cache_unit u0 (.*);

  typedef struct packed {
    logic        is_ld;
    logic [2:0]  seg;
    logic        pm;
    logic [15:0] sel;
    logic [63:0] desc;
    logic [31:0] off;
    logic [1:0]  sz;
    logic        fault;
    logic [31:0] addr;
    logic [9:0]  attr;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk_ld(logic [2:0] s, logic pm, logic [15:0] sel, logic [63:0] d);
    return '{is_ld: 1'b1, seg: s, pm: pm, sel: sel, desc: d, off: '0, sz: '0,
             fault: 1'b0, addr: '0, attr: '0, req: '0};
  endfunction

  function automatic vec_t mk_ck(logic [2:0] s, logic [31:0] o, logic [1:0] z,
                                 logic f, logic [31:0] a, logic [9:0] at, logic [3:0] r);
    return '{is_ld: 1'b0, seg: s, pm: 1'b0, sel: '0, desc: '0, off: o, sz: z,
             fault: f, addr: a, attr: at, req: r};
  endfunction

  localparam int NV = 30;
  // Requirement tags per check: R1 R2 R3 R4 R5 R6 R7 R8 R9
  localparam vec_t VEC [NV] = '{
    mk_ck(3'd2, 32'h0000FFFF, 2'd0, 1'b0, 32'h0000FFFF, 10'h24C, 4'd1),
    mk_ck(3'd2, 32'h00010000, 2'd0, 1'b1, 32'h0,        10'h24C, 4'd5),
    mk_ck(3'd2, 32'h0000FFFE, 2'd1, 1'b0, 32'h0000FFFE, 10'h24C, 4'd5),
    mk_ck(3'd2, 32'h0000FFFE, 2'd2, 1'b1, 32'h0,        10'h24C, 4'd5),
    mk_ck(3'd0, 32'h00000010, 2'd0, 1'b0, 32'hFFFF0010, 10'h26C, 4'd1),
    mk_ld(3'd2, 1'b0, 16'h1234, 64'h0),
    mk_ck(3'd2, 32'h00000005, 2'd0, 1'b0, 32'h00012345, 10'h24C, 4'd2),
    mk_ld(3'd2, 1'b1, 16'h0008, 64'h008F92000000FFFF),
    mk_ck(3'd2, 32'hFFFFFFFF, 2'd0, 1'b0, 32'hFFFFFFFF, 10'h24A, 4'd4),
    mk_ld(3'd2, 1'b0, 16'h0100, 64'h0),
    mk_ck(3'd2, 32'h00200000, 2'd2, 1'b0, 32'h00201000, 10'h24E, 4'd2),
    mk_ck(3'd2, 32'hFFFFFFFE, 2'd1, 1'b0, 32'h00000FFE, 10'h24E, 4'd6),
    mk_ck(3'd2, 32'hFFFFFFFE, 2'd2, 1'b1, 32'h0,        10'h24E, 4'd5),
    mk_ld(3'd3, 1'b1, 16'h0010, 64'h0040F24000000FFF),
    mk_ck(3'd3, 32'h00000FFF, 2'd0, 1'b0, 32'h00400FFF, 10'h3C9, 4'd3),
    mk_ck(3'd3, 32'h00001000, 2'd0, 1'b1, 32'h0,        10'h3C9, 4'd5),
    mk_ld(3'd3, 1'b0, 16'h2000, 64'h0),
    mk_ck(3'd3, 32'h00000010, 2'd0, 1'b0, 32'h00020010, 10'h3CD, 4'd8),
    mk_ck(3'd3, 32'h00001000, 2'd0, 1'b1, 32'h0,        10'h3CD, 4'd2),
    mk_ld(3'd0, 1'b1, 16'h0018, 64'h00CF18000000FFFF),
    mk_ck(3'd0, 32'h00000000, 2'd0, 1'b0, 32'h00000000, 10'h063, 4'd3),
    mk_ld(3'd0, 1'b0, 16'hF000, 64'h0),
    mk_ck(3'd0, 32'h00012345, 2'd0, 1'b0, 32'h00102345, 10'h26F, 4'd7),
    mk_ld(3'd1, 1'b1, 16'h0020, 64'h00005000000000FF),
    mk_ld(3'd1, 1'b0, 16'h0001, 64'h0),
    mk_ck(3'd1, 32'h000000FF, 2'd0, 1'b0, 32'h0000010F, 10'h144, 4'd8),
    mk_ck(3'd1, 32'h000000FF, 2'd1, 1'b1, 32'h0,        10'h144, 4'd9),
    mk_ck(3'd5, 32'h0000FFF8, 2'd3, 1'b0, 32'h0000FFF8, 10'h24C, 4'd5),
    mk_ck(3'd5, 32'h0000FFF9, 2'd3, 1'b1, 32'h0,        10'h24C, 4'd5),
    mk_ck(3'd6, 32'h00000000, 2'd0, 1'b1, 32'h0,        10'h000, 4'd5)
  };

  task automatic check_rsp(input int req, input logic f, input logic [31:0] a,
                           input logic [9:0] at);
    logic [7:0] ev;
    ev = f ? 8'd13 : 8'd0;
    n_run++;
    if (rsp_valid !== 1'b1 || rsp_fault !== f || rsp_addr !== a ||
        rsp_attr !== at || rsp_vec !== ev) begin
      n_fail++;
      $display("FAIL R%0d: got v=%b f=%b addr=%h attr=%h vec=%0d, expected v=1 f=%b addr=%h attr=%h vec=%0d",
               req, rsp_valid, rsp_fault, rsp_addr, rsp_attr, rsp_vec, f, a, at, ev);
    end
  endtask

  task automatic do_load(input logic [2:0] s, input logic pm, input logic [15:0] sel,
                         input logic [63:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = s; ld_pm = pm; ld_sel = sel; ld_desc = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_check(input logic [2:0] s, input logic [31:0] o, input logic [1:0] z);
    @(negedge clk);
    chk_valid = 1'b1; chk_seg = s; chk_off = o; chk_size = z;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R10: idle port state after reset
    n_run++;
    if (rsp_valid !== 1'b0 || ld_ready !== 1'b1 || chk_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: got rsp_valid=%b ld_ready=%b chk_ready=%b, expected 0 1 1",
               rsp_valid, ld_ready, chk_ready);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_ld) begin
        do_load(VEC[i].seg, VEC[i].pm, VEC[i].sel, VEC[i].desc);
      end else begin
        do_check(VEC[i].seg, VEC[i].off, VEC[i].sz);
        check_rsp(int'(VEC[i].req), VEC[i].fault, VEC[i].addr, VEC[i].attr);
      end
    end

    // R11: load and check together see the old base, next check sees new base
    @(negedge clk);
    ld_valid = 1'b1; ld_seg = 3'd4; ld_pm = 1'b0; ld_sel = 16'h0500;
    chk_valid = 1'b1; chk_seg = 3'd4; chk_off = 32'h1; chk_size = 2'd0;
    @(negedge clk);
    ld_valid = 1'b0; chk_valid = 1'b0;
    check_rsp(11, 1'b0, 32'h00000001, 10'h24C);
    do_check(3'd4, 32'h1, 2'd0);
    check_rsp(11, 1'b0, 32'h00005001, 10'h24C);

    // R10: back-pressure holds the response and stalls the check port
    @(negedge clk);
    rsp_ready = 1'b0;
    chk_valid = 1'b1; chk_seg = 3'd4; chk_off = 32'h2; chk_size = 2'd0;
    @(negedge clk);
    chk_off = 32'h3;
    for (int k = 0; k < 3; k++) begin
      n_run++;
      if (chk_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R10: got chk_ready=%b, expected 0", chk_ready);
      end
      check_rsp(10, 1'b0, 32'h00005002, 10'h24C);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk_valid = 1'b0;
    check_rsp(10, 1'b0, 32'h00005003, 10'h24C);

    // R1: reset restores the default caches
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_check(3'd2, 32'h0, 2'd0);
    check_rsp(1, 1'b0, 32'h0, 10'h24C);
    do_check(3'd2, 32'h00010000, 2'd0);
    check_rsp(1, 1'b1, 32'h0, 10'h24C);
    do_check(3'd0, 32'h0, 2'd0);
    check_rsp(1, 1'b0, 32'hFFFF0000, 10'h26C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule